// File: doc/BRIEF.md
# CAN System Error Lockout Controller

This block guards the transmit side of a CAN FD controller against system-level addressing faults. Two strobes report the faults: a message object that was set up with an invalid buffer address, and a received message whose destination cannot be written. When either fault arrives, the block aborts any frame in progress, drives the transmit pin recessive and masks every transmit request. It then moves the controller into one of two fault modes, chosen by a configuration input. Reception stays enabled, so incoming frames keep arriving.

A sticky system error flag records the fault for software. Clearing the flag does not end the lockout. Only a request for configuration mode releases the pin force and the request masking. A request to run then takes the controller from configuration back to normal operation. Bit timing, framing and the receive datapath are handled elsewhere. This block only gates transmission and raises the flag.

Top module: `can_syserr_lockout`

## Requirements
- R1: While reset is held, `mode_o` is configuration (2'b01), and `serr_o`, `pe_abort_o` and `rx_en_o` are 0.
- R2: In configuration mode, `run_req_i` without `cfg_req_i` moves `mode_o` to normal (2'b00) on the next clock.
- R3: In normal mode, a fault on either source without `cfg_req_i` moves `mode_o` on the next clock to restricted (2'b10) if `lock_restrict_i` was 1 in the fault cycle, or to listen-only (2'b11) if it was 0. Later changes of `lock_restrict_i` do not change the mode. Bit 1 of `mode_o` set means lockout.
- R4: `pe_abort_o` is high for exactly the one cycle after a fault that takes normal mode into lockout while `pe_busy_i` is high. It stays low for a fault while `pe_busy_i` is low, and for a fault in any other mode.
- R5: In lockout, `tx_pin_o` is 1 whatever the value of `pe_tx_i`. Outside lockout it equals `pe_tx_i`.
- R6: In lockout, `txreq_o` is all zeros. Outside lockout it equals `txreq_i`.
- R7: Any fault, in any mode, sets `serr_o` on the next clock. The flag stays set until `serr_clr_i` is high with no fault in the same cycle; a fault wins over a clear.
- R8: Clearing `serr_o` and asserting `run_req_i` both leave the lockout mode unchanged.
- R9: `cfg_req_i` moves any mode to configuration on the next clock, which releases the pin force and the request mask. It takes priority over a simultaneous fault for the mode and the abort, but the flag is still set.
- R10: `rx_en_o` is 1 in normal, restricted and listen-only modes, and 0 in configuration.
- R11: Faults on both sources in the same cycle cause one transition and one single-cycle abort pulse. Further faults while in lockout change neither the mode nor the abort output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fault_cfgaddr_i | input | 1 | Strobe: a message object has an invalid buffer address |
| fault_rxdest_i | input | 1 | Strobe: received message targets an unwritable destination |
| pe_busy_i | input | 1 | Protocol engine is transmitting a frame |
| pe_tx_i | input | 1 | Transmit bit from the protocol engine |
| lock_restrict_i | input | 1 | Fault mode select: 1 restricted, 0 listen-only |
| cfg_req_i | input | 1 | Software request for configuration mode |
| run_req_i | input | 1 | Software request for normal mode (from configuration) |
| serr_clr_i | input | 1 | Software clear of the system error flag |
| txreq_i | input | NOBJ | Per-object transmit requests |
| tx_pin_o | output | 1 | Gated transmit pin |
| pe_abort_o | output | 1 | Abort strobe to the protocol engine |
| mode_o | output | 2 | Operating mode: 00 normal, 01 config, 10 restricted, 11 listen-only |
| txreq_o | output | NOBJ | Masked transmit requests |
| serr_o | output | 1 | Sticky system error flag |
| rx_en_o | output | 1 | Receive path enable |

## Verification
The bench targets several corner cases. A fault and a flag clear in the same cycle must leave the flag set; a design that lets the clear win would lose the error. A run request and a flag clear during lockout must leave the block locked; a design that treats either as an exit would start transmitting again with the fault still unresolved. Two more cases cover the abort pulse. A fault that repeats in lockout or lands in configuration must not pulse it, and neither must a configuration request in the same cycle as a fault; a faulty design would abort a frame the engine is not sending. The bench also changes the mode select after entry to catch a design that does not latch the select at the fault.

// File: rtl/can_syserr_lockout.sv
module can_syserr_lockout #(
  parameter int NOBJ = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fault_cfgaddr_i,
  input  logic            fault_rxdest_i,
  input  logic            pe_busy_i,
  input  logic            pe_tx_i,
  input  logic            lock_restrict_i,
  input  logic            cfg_req_i,
  input  logic            run_req_i,
  input  logic            serr_clr_i,
  input  logic [NOBJ-1:0] txreq_i,
  output logic            tx_pin_o,
  output logic            pe_abort_o,
  output logic [1:0]      mode_o,
  output logic [NOBJ-1:0] txreq_o,
  output logic            serr_o,
  output logic            rx_en_o
);
  localparam logic [1:0] M_RUN    = 2'b00;
  localparam logic [1:0] M_CFG    = 2'b01;
  localparam logic [1:0] M_RESTR  = 2'b10;
  localparam logic [1:0] M_LISTEN = 2'b11;

  logic [1:0] mode_q, mode_d;
  logic       flag_q, abort_q;

  wire any_fault = fault_cfgaddr_i | fault_rxdest_i;
  wire locked    = mode_q[1];
  wire enter     = (mode_q == M_RUN) && any_fault && !cfg_req_i;

  always_comb begin
    mode_d = mode_q;
    if (cfg_req_i)
      mode_d = M_CFG;
    else if (mode_q == M_CFG && run_req_i)
      mode_d = M_RUN;
    else if (enter)
      mode_d = lock_restrict_i ? M_RESTR : M_LISTEN;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q  <= M_CFG;
      flag_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      abort_q <= enter && pe_busy_i;
      if (any_fault)       flag_q <= 1'b1;
      else if (serr_clr_i) flag_q <= 1'b0;
    end
  end

  assign mode_o     = mode_q;
  assign serr_o     = flag_q;
  assign pe_abort_o = abort_q;
  assign tx_pin_o   = locked | pe_tx_i;
  assign txreq_o    = locked ? '0 : txreq_i;
  assign rx_en_o    = (mode_q != M_CFG);
endmodule

// File: rtl/can_syserr_lockout_chk.sv
module can_syserr_lockout_chk #(
  parameter int NOBJ = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fault_cfgaddr_i,
  input logic            fault_rxdest_i,
  input logic            pe_busy_i,
  input logic            pe_tx_i,
  input logic            lock_restrict_i,
  input logic            cfg_req_i,
  input logic            run_req_i,
  input logic            serr_clr_i,
  input logic [NOBJ-1:0] txreq_i,
  input logic            tx_pin_o,
  input logic            pe_abort_o,
  input logic [1:0]      mode_o,
  input logic [NOBJ-1:0] txreq_o,
  input logic            serr_o,
  input logic            rx_en_o
);
  a_r2_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && run_req_i && !cfg_req_i) |=> mode_o == 2'b00);

  a_r3_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && (fault_cfgaddr_i || fault_rxdest_i) && !cfg_req_i)
      |=> mode_o == {1'b1, !$past(lock_restrict_i)});

  a_r4_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_abort_o |=> !pe_abort_o);

  a_r4_abort_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_abort_o |-> ($past(pe_busy_i) && mode_o[1]));

  a_r5_tx_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> tx_pin_o);

  a_r5_tx_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[1] |-> tx_pin_o == pe_tx_i);

  a_r6_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] |-> txreq_o == '0);

  a_r6_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[1] |-> txreq_o == txreq_i);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serr_o && !serr_clr_i) |=> serr_o);

  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_cfgaddr_i || fault_rxdest_i) |=> serr_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && !cfg_req_i) |=> $stable(mode_o));

  a_r9_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i |=> (mode_o == 2'b01 && !pe_abort_o));

  a_r10_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_o == (mode_o != 2'b01));
endmodule

bind can_syserr_lockout can_syserr_lockout_chk #(.NOBJ(NOBJ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .fault_cfgaddr_i(fault_cfgaddr_i), .fault_rxdest_i(fault_rxdest_i),
  .pe_busy_i(pe_busy_i), .pe_tx_i(pe_tx_i), .lock_restrict_i(lock_restrict_i),
  .cfg_req_i(cfg_req_i), .run_req_i(run_req_i), .serr_clr_i(serr_clr_i),
  .txreq_i(txreq_i), .tx_pin_o(tx_pin_o), .pe_abort_o(pe_abort_o),
  .mode_o(mode_o), .txreq_o(txreq_o), .serr_o(serr_o), .rx_en_o(rx_en_o)
);

// File: tb/can_syserr_lockout_tb_top.sv
module can_syserr_lockout_tb_top;
  localparam int NOBJ = 32;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0]      mode;
    logic            flag;
    logic            abort;
    logic            txpin;
    logic            rxen;
    logic [NOBJ-1:0] txreq;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fa = 0, fb = 0, busy = 0, petx = 1, rsel = 0, cfg = 0, run = 0, clr = 0;
  logic [NOBJ-1:0] treq = '0;
  logic            tx_pin, abort_o, serr, rx_en;
  logic [1:0]      mode;
  logic [NOBJ-1:0] treq_o;

  int total = 0;
  int bad = 0;
  exp_t q[$];

  logic [1:0] m_mode = 2'b01;
  logic       m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_syserr_lockout #(.NOBJ(NOBJ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fault_cfgaddr_i(fa), .fault_rxdest_i(fb),
    .pe_busy_i(busy), .pe_tx_i(petx), .lock_restrict_i(rsel),
    .cfg_req_i(cfg), .run_req_i(run), .serr_clr_i(clr),
    .txreq_i(treq), .tx_pin_o(tx_pin), .pe_abort_o(abort_o),
    .mode_o(mode), .txreq_o(treq_o), .serr_o(serr), .rx_en_o(rx_en)
  );

  task automatic step(input logic i_fa, input logic i_fb, input logic i_busy,
                      input logic i_rsel, input logic i_cfg, input logic i_run,
                      input logic i_clr, input logic [NOBJ-1:0] i_treq,
                      input logic i_petx, input string tag);
    exp_t e;
    logic anyf;
    logic [1:0] nm;
    @(negedge clk);
    fa = i_fa; fb = i_fb; busy = i_busy; rsel = i_rsel; cfg = i_cfg;
    run = i_run; clr = i_clr; treq = i_treq; petx = i_petx;
    anyf = i_fa | i_fb;
    e.abort = (m_mode == 2'b00) && anyf && i_busy && !i_cfg;
    if (i_cfg) nm = 2'b01;
    else if (m_mode == 2'b01 && i_run) nm = 2'b00;
    else if (m_mode == 2'b00 && anyf) nm = i_rsel ? 2'b10 : 2'b11;
    else nm = m_mode;
    if (anyf) m_flag = 1'b1;
    else if (i_clr) m_flag = 1'b0;
    m_mode  = nm;
    e.mode  = nm;
    e.flag  = m_flag;
    e.txpin = nm[1] ? 1'b1 : i_petx;
    e.txreq = nm[1] ? '0 : i_treq;
    e.rxen  = (nm != 2'b01);
    e.tag   = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (mode !== e.mode || serr !== e.flag || abort_o !== e.abort ||
            tx_pin !== e.txpin || rx_en !== e.rxen || treq_o !== e.txreq) begin
          bad++;
          $display("FAIL %s: mode=%b flag=%b abort=%b txpin=%b rxen=%b txreq=%h expected mode=%b flag=%b abort=%b txpin=%b rxen=%b txreq=%h",
                   e.tag, mode, serr, abort_o, tx_pin, rx_en, treq_o,
                   e.mode, e.flag, e.abort, e.txpin, e.rxen, e.txreq);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    total++;
    if (mode !== 2'b01 || serr !== 1'b0 || abort_o !== 1'b0 || rx_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: mode=%b flag=%b abort=%b rxen=%b expected 01 0 0 0",
               mode, serr, abort_o, rx_en);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R2 R10: config to normal, requests and pin pass through (R5 R6)
    step(0,0,0,0,0,1,0, 32'h0000_00F1, 1, "R2");
    step(0,0,1,0,0,0,0, 32'hA5A5_0003, 0, "R5");
    step(0,0,1,1,0,0,0, 32'h8000_0001, 1, "R6");
    // R3 R4 R7: fault with busy, restricted select
    step(1,0,1,1,0,0,0, 32'hFFFF_FFFF, 0, "R3");
    // R3: later select change ignored; R5 R6 forced / masked; abort gone (R4)
    step(0,0,1,0,0,0,0, 32'h1234_5678, 0, "R5");
    step(0,0,0,0,0,0,0, 32'hFFFF_FFFF, 0, "R6");
    // R8: run and clear do not leave lockout
    step(0,0,0,0,0,1,1, 32'h0000_0001, 0, "R8");
    // R4 R11: fault again in lockout, no abort, flag set again
    step(0,1,1,0,0,0,0, 32'h0000_0002, 1, "R11");
    // R7: clear and fault same cycle, fault wins
    step(1,0,0,0,0,0,1, 32'h0, 0, "R7");
    step(0,0,0,0,0,0,0, 32'h0, 0, "R10");
    // R9: config releases force and mask
    step(0,0,0,0,1,0,0, 32'h0F0F_0F0F, 0, "R9");
    // R7: fault in config sets flag only
    step(0,1,1,1,0,0,1, 32'h0F0F_0F0F, 1, "R7");
    step(0,0,0,0,0,0,1, 32'h0, 1, "R7");
    step(0,0,0,0,0,1,0, 32'h0000_0010, 0, "R2");
    // R11: both sources at once, listen-only, single abort
    step(1,1,1,0,0,0,0, 32'h0000_0010, 0, "R11");
    step(1,1,1,1,0,0,0, 32'h0000_0010, 0, "R11");
    step(0,0,1,0,0,0,0, 32'h0000_0010, 0, "R4");
    // R9: config plus fault in the same cycle
    step(1,0,1,1,1,0,0, 32'h0000_0020, 1, "R9");
    step(0,0,0,0,0,1,1, 32'h0000_0020, 0, "R2");
    step(0,1,1,1,1,0,0, 32'h0000_0040, 0, "R9");
    step(0,0,0,0,0,1,1, 32'h0000_0040, 0, "R2");
    // R4: fault while idle, no abort
    step(1,0,0,1,0,0,0, 32'hDEAD_BEEF, 0, "R4");
    step(0,0,0,1,0,0,0, 32'hDEAD_BEEF, 0, "R5");
    step(0,0,0,0,1,0,1, 32'hDEAD_BEEF, 0, "R9");
    step(0,0,0,0,0,0,0, 32'h0, 1, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule